// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Controller

This block steers one waveform capture into an external sample memory. A host starts a capture after it sets how many memory words to keep before the trigger and how many to keep after it. The controller streams incoming sample words (eight 8-bit samples per word) into memory at a circular address. It does not arm until the requested pre-trigger history is in memory. It then takes the first trigger from a separate trigger-detection block, keeps the requested number of words after the trigger word, and stops.

When the capture is over, the controller holds the address of the word that contained the trigger and raises a finished flag. The host polls that flag and then reads the memory, starting from the trigger address minus the pre-trigger count, modulo the buffer depth. A later start command from the finished state clears the flag and begins a new capture. An abort input returns the controller to idle from any state.

Top module: `acq_ctrl`

## Requirements
- R1: During reset and in the cycle after it, `state_o` is 0 (idle), `done_o` is 0, `mem_we_o` is 0 and `trig_addr_o` is 0.
- R2: When `start_i` is high in idle, the next state is 1 (pre-fill) and the first written word goes to address 0. While a capture is running (states 1, 2, 3), `start_i` has no effect.
- R3: In states 1, 2 and 3, `mem_we_o` follows `sample_valid_i` in the same cycle and `mem_data_o` equals `sample_i`. Each written word goes to the address after the previous one, modulo 2^ADDR_W.
- R4: In state 1, `trig_i` is ignored. The state becomes 2 (armed) in the cycle after the pre-count-th word is written.
- R5: In state 2, a cycle with `trig_i` and `sample_valid_i` both high writes the trigger word. `trig_addr_o` takes that word's address, and the state becomes 3 (post-fill).
- R6: After the trigger word, exactly post-count further words are written. The state then becomes 4 (done). `done_o` is high only in state 4, and no writes happen in states 0 or 4.
- R7: `start_i` in state 4 clears `done_o` in the next cycle and begins a new capture at address 0.
- R8: `abort_i` sends the state to 0 in the next cycle from any state, with priority over `start_i`.
- R9: A pre-count of zero makes the start go straight to state 2, so the first word can be the trigger word.
- R10: The pre-count and post-count are sampled at the start command. Changes on those inputs during a capture have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start command from host |
| abort_i | input | 1 | Abort command from host |
| pre_cnt_i | input | CNT_W | Words to keep before trigger |
| post_cnt_i | input | CNT_W | Words to keep after trigger word |
| trig_i | input | 1 | Trigger event, aligned with the sample word |
| sample_valid_i | input | 1 | A sample word is present |
| sample_i | input | SAMPLES*SAMPLE_W | Packed sample word |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_data_o | output | SAMPLES*SAMPLE_W | Memory write data |
| trig_addr_o | output | ADDR_W | Address of the trigger word |
| done_o | output | 1 | Capture finished flag |
| state_o | output | 3 | State: 0 idle, 1 pre-fill, 2 armed, 3 post-fill, 4 done |

## Verification
The bench holds the trigger high during pre-fill. A controller that armed early would then record a trigger address inside the history window. The bench also runs captures long enough that the address wraps. A design that stopped at the top of the buffer, or reset the address on wrap, would write to the wrong place and report the wrong trigger address. Zero pre-count and zero post-count are both run, because off-by-one counting shows up there as an extra or a missing word.

Idle cycles on the valid input expose a design that counts clocks instead of words. Start pulses during a capture check that the pointer is not reset. Abort is applied together with start, and a design that gave start priority would stay busy. The count inputs are changed in the middle of each capture, which catches any design that does not latch them at the start command.

// File: rtl/acq_ctrl.sv
module acq_ctrl #(
  parameter int ADDR_W   = 10,
  parameter int CNT_W    = 16,
  parameter int SAMPLES  = 8,
  parameter int SAMPLE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         abort_i,
  input  logic [CNT_W-1:0]             pre_cnt_i,
  input  logic [CNT_W-1:0]             post_cnt_i,
  input  logic                         trig_i,
  input  logic                         sample_valid_i,
  input  logic [SAMPLES*SAMPLE_W-1:0]  sample_i,
  output logic                         mem_we_o,
  output logic [ADDR_W-1:0]            mem_addr_o,
  output logic [SAMPLES*SAMPLE_W-1:0]  mem_data_o,
  output logic [ADDR_W-1:0]            trig_addr_o,
  output logic                         done_o,
  output logic [2:0]                   state_o
);
  localparam logic [CNT_W-1:0]  CNT_ONE = 1;
  localparam logic [ADDR_W-1:0] ADR_ONE = 1;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_PRE = 3'd1, S_ARMED = 3'd2, S_POST = 3'd3, S_DONE = 3'd4
  } st_t;

  st_t               st;
  logic [ADDR_W-1:0] ptr, trig_q;
  logic [CNT_W-1:0]  cnt, pre_q, post_q;
  logic              running, wr, cnt_hit_pre, cnt_hit_post;

  assign running      = (st == S_PRE) || (st == S_ARMED) || (st == S_POST);
  assign wr           = running && sample_valid_i;
  assign cnt_hit_pre  = (cnt + CNT_ONE) == pre_q;
  assign cnt_hit_post = (cnt + CNT_ONE) == post_q;

  assign mem_we_o    = wr;
  assign mem_addr_o  = ptr;
  assign mem_data_o  = sample_i;
  assign trig_addr_o = trig_q;
  assign done_o      = (st == S_DONE);
  assign state_o     = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= '0;
      trig_q <= '0;
      cnt    <= '0;
      pre_q  <= '0;
      post_q <= '0;
    end else if (abort_i) begin
      st <= S_IDLE;
    end else begin
      if (wr) ptr <= ptr + ADR_ONE;
      case (st)
        S_IDLE, S_DONE: if (start_i) begin
          ptr    <= '0;
          cnt    <= '0;
          pre_q  <= pre_cnt_i;
          post_q <= post_cnt_i;
          st     <= (pre_cnt_i == '0) ? S_ARMED : S_PRE;
        end
        S_PRE: if (sample_valid_i) begin
          if (cnt_hit_pre) begin
            cnt <= '0;
            st  <= S_ARMED;
          end else begin
            cnt <= cnt + CNT_ONE;
          end
        end
        S_ARMED: if (sample_valid_i && trig_i) begin
          trig_q <= ptr;
          cnt    <= '0;
          st     <= (post_q == '0) ? S_DONE : S_POST;
        end
        S_POST: if (sample_valid_i) begin
          if (cnt_hit_post) st <= S_DONE;
          else              cnt <= cnt + CNT_ONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && !abort_i) |=> (mem_addr_o == $past(mem_addr_o) + ADR_ONE));

  // R4
  pre_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRE && !abort_i) |=> (st == S_PRE || st == S_ARMED));

  // R5
  trig_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARMED && trig_i && sample_valid_i && !abort_i) |=> (trig_addr_o == $past(mem_addr_o)));

  // R6
  done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(st) == S_POST || $past(st) == S_ARMED));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && start_i && !abort_i) |=> (!done_o && mem_addr_o == '0));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (st == S_IDLE));
endmodule

// File: tb/sim_acq_ctrl.sv
module sim_acq_ctrl;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0, start_i = 0, abort_i = 0, trig_i = 0, sample_valid_i = 0;
  logic [CW-1:0] pre_cnt_i = '0, post_cnt_i = '0;
  logic [63:0] sample_i = '0;
  logic mem_we_o, done_o;
  logic [AW-1:0] mem_addr_o, trig_addr_o;
  logic [63:0] mem_data_o;
  logic [2:0] state_o;
  int checks = 0, errors = 0;

  acq_ctrl #(.ADDR_W(AW), .CNT_W(CW), .SAMPLES(8), .SAMPLE_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .pre_cnt_i(pre_cnt_i), .post_cnt_i(post_cnt_i), .trig_i(trig_i),
    .sample_valid_i(sample_valid_i), .sample_i(sample_i),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .trig_addr_o(trig_addr_o), .done_o(done_o), .state_o(state_o));

  always #5 clk = ~clk;

  // pre, post, trigger-after index, gapped valid
  localparam logic [31:0] VEC [6] = '{
    {8'd3,  8'd4,  8'd0,  8'd0},
    {8'd5,  8'd2,  8'd9,  8'd0},
    {8'd0,  8'd3,  8'd0,  8'd0},
    {8'd4,  8'd0,  8'd6,  8'd1},
    {8'd12, 8'd10, 8'd14, 8'd0},
    {8'd2,  8'd5,  8'd20, 8'd1}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int i);
    logic [7:0] b = 8'(i * 37 + 5);
    return {8{b}};
  endfunction

  task automatic run_cap(input int pre, input int post, input int ta, input int gap);
    int idx = 0, cyc = 0;
    int tidx = (ta > pre) ? ta : pre;
    int total = tidx + 1 + post;
    @(negedge clk);
    start_i = 1; pre_cnt_i = CW'(pre); post_cnt_i = CW'(post);
    sample_valid_i = 0; trig_i = 0;
    @(negedge clk);
    start_i = 0; pre_cnt_i = '1; post_cnt_i = '1; // R10: changed after start
    chk("R7 done cleared", done_o, 0);
    if (pre == 0) chk("R9 start state", state_o, 2);
    else          chk("R2 start state", state_o, 1);
    while (!done_o && cyc < 400) begin
      if (idx < pre)       chk("R4 trigger ignored in pre-fill", state_o, 1);
      else if (idx <= tidx) chk("R4 armed after pre-count", state_o, 2);
      sample_valid_i = gap ? (cyc % 2 == 1) : 1'b1;
      trig_i = (idx >= ta);
      sample_i = pat(idx);
      #1;
      chk("R3 write enable", mem_we_o, sample_valid_i);
      if (mem_we_o) begin
        chk("R3 address", mem_addr_o, idx % DEPTH);
        chk("R3 data", mem_data_o, pat(idx));
        idx++;
      end
      @(negedge clk);
      cyc++;
    end
    chk("R6 words written", idx, total);
    chk("R10 trigger address", trig_addr_o, tidx % DEPTH);
    chk("R5 trigger address", trig_addr_o, tidx % DEPTH);
    sample_valid_i = 1; trig_i = 0;
    #1;
    chk("R6 no write in done", mem_we_o, 0);
    chk("R6 done flag", done_o, 1);
    sample_valid_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R6 watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 state in reset", state_o, 0);
    rst_n = 1;
    @(negedge clk);
    sample_valid_i = 1;
    #1;
    chk("R1 state", state_o, 0);
    chk("R1 done", done_o, 0);
    chk("R6 no write in idle", mem_we_o, 0);
    chk("R1 trigger address", trig_addr_o, 0);
    sample_valid_i = 0;

    for (int i = 0; i < 6; i++)
      run_cap(int'(VEC[i][31:24]), int'(VEC[i][23:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]));

    // start ignored while running, then abort beats start
    @(negedge clk);
    start_i = 1; pre_cnt_i = 6; post_cnt_i = 2;
    @(negedge clk);
    start_i = 0; sample_valid_i = 1; trig_i = 0;
    repeat (3) @(negedge clk);
    start_i = 1;
    #1;
    chk("R2 start ignored addr", mem_addr_o, 3);
    @(negedge clk);
    chk("R2 start ignored state", state_o, 1);
    chk("R2 start ignored addr next", mem_addr_o, 4);
    abort_i = 1; start_i = 1;
    @(negedge clk);
    abort_i = 0; start_i = 0;
    #1;
    chk("R8 abort beats start", state_o, 0);
    chk("R8 no write after abort", mem_we_o, 0);
    sample_valid_i = 0;

    // abort from armed
    @(negedge clk);
    start_i = 1; pre_cnt_i = 0; post_cnt_i = 1;
    @(negedge clk);
    start_i = 0;
    chk("R9 armed", state_o, 2);
    abort_i = 1;
    @(negedge clk);
    abort_i = 0;
    chk("R8 abort from armed", state_o, 0);

    // abort from done
    run_cap(1, 1, 0, 0);
    abort_i = 1;
    @(negedge clk);
    abort_i = 0;
    chk("R8 abort from done state", state_o, 0);
    chk("R8 abort clears done", done_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule